// File: doc/BRIEF.md
# Bitmask Immediate Pattern Expander

This block turns the three compact fields of a logical-immediate encoding into the full 64-bit mask they stand for. The fields are a one-bit N, a six-bit S field and a six-bit R field. A size flag selects 32-bit or 64-bit operation. The block also reports whether the encoding is legal.

The element size comes from the position of the highest set bit in N placed above the inverted S field. A run of ones is built at the bottom of that element. The run is rotated right inside the element, and the element is then tiled from bit 0 upward until the operand width is full. Encodings that are reserved raise no mask and clear the legal flag.

The core is combinational. A two-state controller registers its result one clock edge after an input strobe. In state ST_IDLE no result is being presented. Transition T_ACCEPT goes from ST_IDLE to ST_DONE on a strobe. In state ST_DONE the result of the previous edge is presented with `out_valid` high. Transition T_CHAIN stays in ST_DONE when another strobe arrives. Transition T_RELEASE returns to ST_IDLE when no strobe arrives. A decoder would use the block to form the second operand of AND, OR, XOR and flag-setting AND with immediate.

Top module: `bmask_expander`

## Requirements
- R1: While `rst_n` is low and after it rises, `out_valid`, `mask_ok` and `mask` are all 0 until the first strobe.
- R2: `out_valid` is 1 in exactly the cycle after each cycle in which `in_valid` was 1 at the clock edge, and 0 otherwise.
- R3: The element size is 2^L, where L is the index of the highest set bit of the 7-bit value {n_bit, ~imms}; the mask repeats with that period.
- R4: Each element holds (imms AND (2^L-1)) + 1 ones.
- R5: The run of ones, starting at bit 0 of the element, is rotated right within the element by (immr AND (2^L-1)); for example n_bit=0, imms=6'b100101, immr=2, is_wide=1 gives 64'hC00F_C00F_C00F_C00F.
- R6: With `is_wide`=1 the element is tiled over all 64 bits; with `is_wide`=0 it is tiled over bits 31:0 and bits 63:32 are 0.
- R7: When L is 0 (n_bit=0 and imms is 6'b111110 or 6'b111111), `mask_ok` is 0.
- R8: When the masked imms bits (imms AND (2^L-1)) are all ones, the encoding is reserved and `mask_ok` is 0.
- R9: When n_bit=1 and is_wide=0, `mask_ok` is 0.
- R10: Whenever `mask_ok` is 0, `mask` is 0.
- R11: In a cycle without a strobe, `mask` and `mask_ok` keep their values, whatever the field inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Strobe: capture the fields at this edge |
| is_wide | input | 1 | 1 = 64-bit operation, 0 = 32-bit operation |
| n_bit | input | 1 | N field of the encoding |
| imms | input | 6 | S field: element size and run length |
| immr | input | 6 | R field: right rotation inside the element |
| out_valid | output | 1 | Result presented this cycle |
| mask_ok | output | 1 | Encoding legal |
| mask | output | 64 | Expanded mask, zero when illegal |

## Verification
Every result is due at the first rising edge after the strobe is sampled: one register stage lies between the fields and `mask`, `mask_ok` and `out_valid`. The bench drives each field set on a falling edge with the strobe high. It reads the outputs at the next falling edge, half a period after the capturing edge, and drives the next set at that same moment, so the whole sweep runs back to back. After the last strobe it changes the fields with the strobe low and reads one falling edge later. At that point `out_valid` must already have dropped and the held mask must be unchanged.

// File: rtl/bmask_pkg.sv
package bmask_pkg;
    localparam int BM_WORD_W = 64;
    localparam int BM_FLD_W  = 6;

    typedef enum logic {
        ST_IDLE,
        ST_DONE
    } bm_state_e;
endpackage

// File: rtl/bmask_size_decode.sv
module bmask_size_decode #(
    parameter int FLD_W = 6,
    localparam int LEN_W = $clog2(FLD_W + 1)
) (
    input  logic             n_bit,
    input  logic [FLD_W-1:0] imms,
    input  logic             is_wide,
    output logic [LEN_W-1:0] len_idx,
    output logic [FLD_W-1:0] lvl_mask,
    output logic             enc_ok
);
    logic [FLD_W:0] code;
    assign code = {n_bit, ~imms};

    always_comb begin
        // leading-one position: the last set bit in ascending order wins
        len_idx = '0;
        for (int i = 0; i <= FLD_W; i++) begin
            if (code[i]) len_idx = LEN_W'(i);
        end
        for (int i = 0; i < FLD_W; i++) begin
            lvl_mask[i] = (LEN_W'(i) < len_idx);
        end
        enc_ok = (len_idx != '0)
              && ((imms & lvl_mask) != lvl_mask)
              && !(n_bit && !is_wide);
    end
endmodule

// File: rtl/bmask_elem_build.sv
module bmask_elem_build #(
    parameter int WORD_W = 64,
    parameter int FLD_W  = 6,
    localparam int LEN_W = $clog2(FLD_W + 1),
    localparam int CAND_N = 2 ** LEN_W
) (
    input  logic [LEN_W-1:0]  len_idx,
    input  logic [FLD_W-1:0]  run_m1,
    input  logic [FLD_W-1:0]  rot,
    output logic [WORD_W-1:0] tiled
);
    logic [WORD_W-1:0] cand [CAND_N];

    assign cand[0] = '0;

    // one candidate per element size; the decoded length picks one
    for (genvar k = 1; k <= FLD_W; k++) begin : g_size
        localparam int EW = 1 << k;
        logic [EW-1:0] run;
        logic [EW-1:0] rotd;
        int            sh;

        always_comb begin
            sh   = int'(rot[k-1:0]);
            run  = ~({EW{1'b1}} << (int'(run_m1) + 1));
            rotd = (run >> sh) | (run << (EW - sh));
        end

        assign cand[k] = {(WORD_W / EW){rotd}};
    end

    for (genvar k = FLD_W + 1; k < CAND_N; k++) begin : g_pad
        assign cand[k] = '0;
    end

    assign tiled = cand[len_idx];
endmodule

// File: rtl/bmask_width_fit.sv
module bmask_width_fit #(
    parameter int WORD_W = 64,
    localparam int HALF_W = WORD_W / 2
) (
    input  logic [WORD_W-1:0] tiled,
    input  logic              is_wide,
    input  logic              enc_ok,
    output logic [WORD_W-1:0] mask
);
    always_comb begin
        mask = '0;
        if (enc_ok) begin
            mask = is_wide ? tiled : {{HALF_W{1'b0}}, tiled[HALF_W-1:0]};
        end
    end
endmodule

// File: rtl/bmask_expander.sv
module bmask_expander
    import bmask_pkg::*;
#(
    parameter int WORD_W = BM_WORD_W,
    parameter int FLD_W  = BM_FLD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              is_wide,
    input  logic              n_bit,
    input  logic [FLD_W-1:0]  imms,
    input  logic [FLD_W-1:0]  immr,
    output logic              out_valid,
    output logic              mask_ok,
    output logic [WORD_W-1:0] mask
);
    localparam int LEN_W  = $clog2(FLD_W + 1);
    localparam int HALF_W = WORD_W / 2;

    logic [LEN_W-1:0]  len_idx;
    logic [FLD_W-1:0]  lvl_mask;
    logic              enc_ok;
    logic [FLD_W-1:0]  run_m1;
    logic [FLD_W-1:0]  rot_amt;
    logic [WORD_W-1:0] tiled;
    logic [WORD_W-1:0] mask_nx;

    bm_state_e         state_q, state_nx;
    logic [WORD_W-1:0] mask_q;
    logic              ok_q;
    logic              wide_q;

    bmask_size_decode #(.FLD_W(FLD_W)) size_i (
        .n_bit    (n_bit),
        .imms     (imms),
        .is_wide  (is_wide),
        .len_idx  (len_idx),
        .lvl_mask (lvl_mask),
        .enc_ok   (enc_ok)
    );

    assign run_m1  = imms & lvl_mask;
    assign rot_amt = immr & lvl_mask;

    bmask_elem_build #(.WORD_W(WORD_W), .FLD_W(FLD_W)) elem_i (
        .len_idx (len_idx),
        .run_m1  (run_m1),
        .rot     (rot_amt),
        .tiled   (tiled)
    );

    bmask_width_fit #(.WORD_W(WORD_W)) fit_i (
        .tiled   (tiled),
        .is_wide (is_wide),
        .enc_ok  (enc_ok),
        .mask    (mask_nx)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    // transitions: T_ACCEPT, T_CHAIN, T_RELEASE
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE: if (in_valid) state_nx = ST_DONE;
            ST_DONE: if (!in_valid) state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            ok_q   <= 1'b0;
            wide_q <= 1'b0;
        end else if (in_valid) begin
            mask_q <= mask_nx;
            ok_q   <= enc_ok;
            wide_q <= is_wide;
        end
    end

    assign out_valid = (state_q == ST_DONE);
    assign mask_ok   = ok_q;
    assign mask      = mask_q;

    AST_STROBE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid); // R2
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> !out_valid); // R2
    AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> ($stable(mask) && $stable(mask_ok))); // R11
    AST_BAD_IS_ZERO: assert property (@(posedge clk) disable iff (!rst_n) !mask_ok |-> (mask == '0)); // R10
    AST_NARROW_UPPER: assert property (@(posedge clk) disable iff (!rst_n) (mask_ok && !wide_q) |-> (mask[WORD_W-1:HALF_W] == '0)); // R6
    AST_N_IN_NARROW: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && n_bit && !is_wide) |=> !mask_ok); // R9
endmodule

// File: tb/bmask_expander_tb_top.sv
module bmask_expander_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic        is_wide;
    logic        n_bit;
    logic [5:0]  imms;
    logic [5:0]  immr;
    logic        out_valid;
    logic        mask_ok;
    logic [63:0] mask;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    bmask_expander dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .is_wide   (is_wide),
        .n_bit     (n_bit),
        .imms      (imms),
        .immr      (immr),
        .out_valid (out_valid),
        .mask_ok   (mask_ok),
        .mask      (mask)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h (w=%0d n=%0d s=%b r=%0d)",
                     tag, act, exp, is_wide, n_bit, imms, immr);
        end
    endtask

    // model: bit i of the element is 1 when its rotated source index lies in the run
    function automatic logic [63:0] model(input logic w, input logic n, input logic [5:0] s,
                                          input logic [5:0] r, output logic ok,
                                          output string why, output int esz, output int ones);
        logic [6:0] code;
        int len, lv, sm, rm, wid;
        logic [63:0] res;
        code = {n, ~s};
        len = -1;
        for (int i = 0; i < 7; i++) if (code[i]) len = i;
        ok = 1'b1; why = "R5"; res = '0; esz = 0; ones = 0;
        if (len < 1) begin ok = 1'b0; why = "R7"; return res; end
        lv = (1 << len) - 1;
        sm = int'(s) & lv;
        rm = int'(r) & lv;
        if (n && !w) begin ok = 1'b0; why = "R9"; return res; end
        if (sm == lv) begin ok = 1'b0; why = "R8"; return res; end
        esz  = 1 << len;
        ones = sm + 1;
        wid  = w ? 64 : 32;
        for (int i = 0; i < wid; i++) res[i] = (((i % esz) + rm) % esz) <= sm;
        return res;
    endfunction

    task automatic apply(input logic w, input logic n, input logic [5:0] s, input logic [5:0] r);
        logic [63:0] exp_m;
        logic exp_ok;
        string why;
        int esz, ones, cnt;
        logic per;
        is_wide = w; n_bit = n; imms = s; immr = r; in_valid = 1'b1;
        exp_m = model(w, n, s, r, exp_ok, why, esz, ones);
        @(negedge clk);
        chk("R2 out_valid", {63'd0, out_valid}, 64'd1);
        chk({why, " ok"}, {63'd0, mask_ok}, {63'd0, exp_ok});
        chk({why, " mask"}, mask, exp_m);
        if (!exp_ok) begin
            chk("R10 zero", mask, 64'd0);
        end else begin
            cnt = 0;
            for (int i = 0; i < esz; i++) cnt += int'(mask[i]);
            chk("R4 ones", 64'(cnt), 64'(ones));
            per = 1'b1;
            for (int i = 0; i < (w ? 64 : 32); i++) if (mask[i] !== mask[i % esz]) per = 1'b0;
            chk("R3 period", {63'd0, per}, 64'd1);
            if (!w) chk("R6 upper", {32'd0, mask[63:32]}, 64'd0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [63:0] held;
        logic held_ok;
        rst_n = 1'b0; in_valid = 1'b0; is_wide = 1'b1; n_bit = 1'b0; imms = '0; immr = '0;
        repeat (3) @(negedge clk);
        chk("R1 out_valid", {63'd0, out_valid}, 64'd0);
        chk("R1 mask_ok", {63'd0, mask_ok}, 64'd0);
        chk("R1 mask", mask, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", mask, 64'd0);
        chk("R2 idle", {63'd0, out_valid}, 64'd0);

        apply(1'b1, 1'b0, 6'b100101, 6'd2);
        chk("R5 example", mask, 64'hC00F_C00F_C00F_C00F);

        for (int w = 0; w < 2; w++)
            for (int n = 0; n < 2; n++)
                for (int s = 0; s < 64; s++)
                    for (int r = 0; r < 64; r++)
                        apply(w[0], n[0], s[5:0], r[5:0]);

        apply(1'b1, 1'b1, 6'b000000, 6'd5);
        held = mask; held_ok = mask_ok;
        in_valid = 1'b0; is_wide = 1'b0; n_bit = 1'b0; imms = 6'b111111; immr = 6'd7;
        @(negedge clk);
        chk("R2 released", {63'd0, out_valid}, 64'd0);
        chk("R11 mask held", mask, held);
        chk("R11 ok held", {63'd0, mask_ok}, {63'd0, held_ok});
        imms = 6'b000011;
        @(negedge clk);
        chk("R11 mask still held", mask, held);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule